// File: doc/BRIEF.md
# Frame-Synced Parallel Sample Port

This block moves fixed-length lines of samples between a parallel data bus and an internal stream. Each line is triggered by one transition of a frame-sync input. The port then skips a programmable number of clock cycles before it transfers a programmable number of samples, one per clock. In receive direction, bus words are captured and offered downstream on a valid/ready stream. In transmit direction, words are taken from an upstream source and driven onto the bus with an output enable.

A fresh sync that arrives while a line is still running wins. The running line is dropped, a one-cycle truncation pulse is raised, and the skip/transfer sequence starts over. Direction, skip length and sample count are all captured at the sync edge. Register changes made in mid-line therefore affect only the next line.

Top module: `fsync_par_port`

## Requirements
- R1: A line starts only on an inactive-to-active change of `fs_in` as seen at a rising clock edge. With `cfg_fs_low` = 0 the active level is high; with `cfg_fs_low` = 1 it is low.
- R2: In receive direction (`cfg_tx` = 0), take E as the edge where the sync is detected and D as `cfg_delay`. The bus words sampled at edges E+1 through E+1+D are discarded. The first word captured is the one sampled at edge E+2+D.
- R3: In either direction, exactly `cfg_count` (N) words move per uninterrupted line, on consecutive edges. In receive direction `rx_last` is 1 on the N-th word only.
- R4: In transmit direction (`cfg_tx` = 1), `tx_take` is high in the cycles that end at edges E+1+D through E+D+N. The `tx_data` taken at each of those edges appears on `bus_out` with `bus_oe` = 1 in the following cycle. `bus_oe` is 0 at all other times.
- R5: A sync edge that arrives while a line is running abandons that line. The word at that edge is not transferred, `rx_last` is never raised for the abandoned line, and the new line follows R2–R4 timed from the new edge.
- R6: A pre-empted line causes `line_truncated` to be high for exactly the one cycle after the pre-empting edge.
- R7: Direction, delay and count are captured at the sync edge. Changing them during a line does not alter that line.
- R8: A sync edge seen while `cfg_count` = 0 is ignored. It starts nothing, does not pre-empt a running line, and raises no truncation.
- R9: `rx_valid` stays high, with `rx_data`/`rx_last` stable, until `rx_ready` is sampled high. If a new word is captured while an unaccepted word is held, the new word replaces it and `rx_overrun` pulses for one cycle.
- R10: After reset, `rx_valid`, `bus_oe`, `tx_take`, `line_truncated` and `rx_overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tx | input | 1 | Line direction: 1 transmit, 0 receive |
| cfg_fs_low | input | 1 | Sync polarity: 1 means low is active |
| cfg_delay | input | CNT_W | Cycles skipped before the transfer |
| cfg_count | input | CNT_W | Words per line; 0 disables the port |
| fs_in | input | 1 | Frame-sync input |
| bus_in | input | DATA_W | Parallel bus, receive side |
| bus_out | output | DATA_W | Parallel bus, transmit side |
| bus_oe | output | 1 | Bus output enable |
| tx_data | input | DATA_W | Upstream word to transmit |
| tx_take | output | 1 | Upstream word consumed at this edge |
| rx_data | output | DATA_W | Captured word |
| rx_valid | output | 1 | Captured word available |
| rx_last | output | 1 | Final word of a complete line |
| rx_ready | input | 1 | Downstream accepts the word |
| rx_overrun | output | 1 | Held word overwritten |
| line_truncated | output | 1 | Line abandoned by an early sync |

## Verification
The assertions assume that `fs_in` stays inactive for at least one cycle between pulses, so that edges are never adjacent. They also assume that the configuration inputs are stable from the negedge before a sync edge through that edge. The bench drives every sync as a one-cycle pulse from a negedge and changes the configuration only at negedges. When it flips polarity, it moves `fs_in` in the same step so that the corrected level stays inactive. The bus and the upstream word come from one free-running counter, so every expected word follows from the edge index alone.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_GAP  = 2'd1,
      PH_WAIT = 2'd2,
      PH_XFER = 2'd3
   } phase_t;
endpackage

// File: rtl/fsp_sync_edge.sv
module fsp_sync_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic fs_raw,
   input  logic fs_low,
   output logic fs_rise
);
   logic fs_act;
   logic fs_act_q;

   assign fs_act  = fs_raw ^ fs_low;
   assign fs_rise = fs_act & ~fs_act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fs_act_q <= 1'b0;
      else        fs_act_q <= fs_act;
   end
endmodule

// File: rtl/fsp_line_seq.sv
module fsp_line_seq
   import fsp_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fs_rise,
   input  logic             cfg_tx,
   input  logic [CNT_W-1:0] cfg_delay,
   input  logic [CNT_W-1:0] cfg_count,
   output logic             beat,
   output logic             last_beat,
   output logic             line_is_tx,
   output logic             preempt
);
   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   phase_t           phase;
   logic [CNT_W-1:0] dly_left;
   logic [CNT_W-1:0] smp_left;
   logic             go;

   assign go        = fs_rise && (cfg_count != ZERO);
   assign beat      = (phase == PH_XFER) && !go;
   assign last_beat = beat && (smp_left == ONE);
   assign preempt   = go && (phase != PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         dly_left   <= ZERO;
         smp_left   <= ZERO;
         line_is_tx <= 1'b0;
      end else if (go) begin
         line_is_tx <= cfg_tx;
         dly_left   <= cfg_delay;
         smp_left   <= cfg_count;
         if (cfg_tx) phase <= (cfg_delay == ZERO) ? PH_XFER : PH_WAIT;
         else        phase <= PH_GAP;
      end else begin
         unique case (phase)
            PH_GAP:  phase <= (dly_left == ZERO) ? PH_XFER : PH_WAIT;
            PH_WAIT: begin
               dly_left <= dly_left - ONE;
               if (dly_left == ONE) phase <= PH_XFER;
            end
            PH_XFER: begin
               smp_left <= smp_left - ONE;
               if (smp_left == ONE) phase <= PH_IDLE;
            end
            default: ;
         endcase
      end
   end

   assert_zero_count_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE && cfg_count == ZERO) |=> phase == PH_IDLE);
   assert_xfer_has_work_R3: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_XFER |-> smp_left != ZERO);
   assert_last_then_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      last_beat |=> phase == PH_IDLE);
   assert_gap_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_GAP && !go) |=> (phase == PH_WAIT || phase == PH_XFER));
   assert_preempt_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (preempt && !cfg_tx) |=> phase == PH_GAP);
endmodule

// File: rtl/fsp_rx_hold.sv
module fsp_rx_hold #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic              cap_last,
   input  logic [DATA_W-1:0] din,
   input  logic              ready,
   output logic [DATA_W-1:0] data,
   output logic              valid,
   output logic              last,
   output logic              overrun
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data    <= '0;
         valid   <= 1'b0;
         last    <= 1'b0;
         overrun <= 1'b0;
      end else begin
         overrun <= cap && valid && !ready;
         if (cap) begin
            data  <= din;
            last  <= cap_last;
            valid <= 1'b1;
         end else if (ready) begin
            valid <= 1'b0;
         end
      end
   end

   assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready && !cap) |=> (valid && $stable(data) && $stable(last)));
   assert_overrun_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cap && valid && !ready) |=> overrun);
endmodule

// File: rtl/fsync_par_port.sv
module fsync_par_port #(
   parameter int DATA_W     = 16,
   parameter int CNT_W      = 16,
   parameter bit SUPPORT_TX = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_tx,
   input  logic              cfg_fs_low,
   input  logic [CNT_W-1:0]  cfg_delay,
   input  logic [CNT_W-1:0]  cfg_count,
   input  logic              fs_in,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_take,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_last,
   input  logic              rx_ready,
   output logic              rx_overrun,
   output logic              line_truncated
);
   if (DATA_W < 1) begin : g_bad_data_w
      $error("fsync_par_port: DATA_W must be at least 1");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
      $error("fsync_par_port: CNT_W must be within 2..32");
   end

   logic fs_rise;
   logic beat;
   logic last_beat;
   logic line_is_tx;
   logic preempt;
   logic rx_cap;

   fsp_sync_edge u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .fs_raw  (fs_in),
      .fs_low  (cfg_fs_low),
      .fs_rise (fs_rise)
   );

   fsp_line_seq #(.CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .fs_rise    (fs_rise),
      .cfg_tx     (cfg_tx),
      .cfg_delay  (cfg_delay),
      .cfg_count  (cfg_count),
      .beat       (beat),
      .last_beat  (last_beat),
      .line_is_tx (line_is_tx),
      .preempt    (preempt)
   );

   assign rx_cap = beat && !line_is_tx;

   fsp_rx_hold #(.DATA_W(DATA_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap      (rx_cap),
      .cap_last (last_beat),
      .din      (bus_in),
      .ready    (rx_ready),
      .data     (rx_data),
      .valid    (rx_valid),
      .last     (rx_last),
      .overrun  (rx_overrun)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_truncated <= 1'b0;
      else        line_truncated <= preempt;
   end

   if (SUPPORT_TX) begin : g_tx
      assign tx_take = beat && line_is_tx;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bus_out <= '0;
            bus_oe  <= 1'b0;
         end else begin
            bus_oe <= tx_take;
            if (tx_take) bus_out <= tx_data;
         end
      end
      assert_oe_not_in_rx_R4: assert property (@(posedge clk) disable iff (!rst_n)
         rx_cap |-> !bus_oe);
   end else begin : g_rx_only
      assign tx_take = 1'b0;
      assign bus_out = '0;
      assign bus_oe  = 1'b0;
   end

   assert_trunc_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      line_truncated |=> !line_truncated);
endmodule

// File: tb/fsync_par_port_tb.sv
module fsync_par_port_tb_top;
   localparam int DW = 16;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_tx = 1'b0;
   logic          cfg_fs_low = 1'b0;
   logic [CW-1:0] cfg_delay = '0;
   logic [CW-1:0] cfg_count = '0;
   logic          fs_act = 1'b0;
   logic          fs_in;
   logic [DW-1:0] pat = '0;
   logic [DW-1:0] bus_out;
   logic          bus_oe;
   logic          tx_take;
   logic [DW-1:0] rx_data;
   logic          rx_valid;
   logic          rx_last;
   logic          rx_ready = 1'b1;
   logic          rx_overrun;
   logic          line_truncated;

   int vectors = 0;
   int errors = 0;
   int trunc_seen = 0;
   int ovr_seen = 0;
   logic [DW:0]   rxq[$];
   logic [DW-1:0] txq[$];

   assign fs_in = fs_act ^ cfg_fs_low;

   always #10 clk = ~clk;

   always @(negedge clk) pat <= pat + 1'b1;

   fsync_par_port #(.DATA_W(DW), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_tx(cfg_tx), .cfg_fs_low(cfg_fs_low),
      .cfg_delay(cfg_delay), .cfg_count(cfg_count), .fs_in(fs_in),
      .bus_in(pat), .bus_out(bus_out), .bus_oe(bus_oe), .tx_data(pat),
      .tx_take(tx_take), .rx_data(rx_data), .rx_valid(rx_valid),
      .rx_last(rx_last), .rx_ready(rx_ready), .rx_overrun(rx_overrun),
      .line_truncated(line_truncated)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard as the port produces words
   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_valid && rx_ready) begin
            if (rxq.size() == 0) check(1'b0, "R2/R3 unexpected rx word", int'(rx_data), -1);
            else begin
               logic [DW:0] e;
               e = rxq.pop_front();
               check({rx_last, rx_data} == e, "R2/R3 rx word", int'({rx_last, rx_data}), int'(e));
            end
         end
         if (bus_oe) begin
            if (txq.size() == 0) check(1'b0, "R4 unexpected bus drive", int'(bus_out), -1);
            else begin
               logic [DW-1:0] t;
               t = txq.pop_front();
               check(bus_out == t, "R4 tx word", int'(bus_out), int'(t));
            end
         end
         if (line_truncated) trunc_seen++;
         if (rx_overrun) ovr_seen++;
      end
   end

   // one-cycle sync pulse; b0 is the bus value at the detecting edge E
   task automatic sync_pulse(input bit tx, input int d, input int n, output logic [DW-1:0] b0);
      @(negedge clk);
      cfg_tx = tx;
      cfg_delay = CW'(d);
      cfg_count = CW'(n);
      fs_act = 1'b1;
      #1 b0 = pat;
      @(negedge clk);
      fs_act = 1'b0;
   endtask

   task automatic push_rx(input logic [DW-1:0] b0, input int d, input int ncap, input bit full);
      for (int i = 0; i < ncap; i++)
         rxq.push_back({full && (i == ncap - 1), b0 + DW'(2 + d + i)});
   endtask

   task automatic push_tx(input logic [DW-1:0] b0, input int d, input int n);
      for (int i = 0; i < n; i++) txq.push_back(b0 + DW'(1 + d + i));
   endtask

   task automatic drain(input string tag);
      repeat (40) @(negedge clk);
      check(rxq.size() == 0 && txq.size() == 0, tag, rxq.size() + txq.size(), 0);
   endtask

   task automatic rx_line(input int d, input int n, input string tag);
      logic [DW-1:0] b;
      sync_pulse(1'b0, d, n, b);
      push_rx(b, d, n, 1'b1);
      drain(tag);
   endtask

   task automatic tx_line(input int d, input int n, input string tag);
      logic [DW-1:0] b;
      sync_pulse(1'b1, d, n, b);
      push_tx(b, d, n);
      drain(tag);
   endtask

   initial begin
      logic [DW-1:0] b;
      int t0;
      repeat (3) @(negedge clk);
      check(!rx_valid && !bus_oe && !tx_take && !line_truncated && !rx_overrun,
            "R10 reset outputs", int'({rx_valid, bus_oe, tx_take, line_truncated}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      rx_line(0, 1, "R2 rx D=0 N=1 drained");
      rx_line(3, 5, "R3 rx D=3 N=5 drained");
      rx_line(1, 12, "R3 rx D=1 N=12 drained");
      tx_line(0, 4, "R4 tx D=0 N=4 drained");
      tx_line(2, 3, "R4 tx D=2 N=3 drained");

      // R1: low-active polarity; flip level together so the corrected level stays idle
      @(negedge clk);
      cfg_fs_low = 1'b1;
      rx_line(2, 4, "R1 low-active sync drained");
      @(negedge clk);
      check(fs_in == 1'b1, "R1 idle level high when low-active", int'(fs_in), 1);
      cfg_fs_low = 1'b0;
      repeat (2) @(negedge clk);

      // R1: a held-active level gives one line only
      sync_pulse(1'b0, 0, 2, b);
      fs_act = 1'b1;
      push_rx(b, 0, 2, 1'b1);
      repeat (10) @(negedge clk);
      fs_act = 1'b0;
      drain("R1 level held gives one line");

      // R7: configuration changed mid-line
      sync_pulse(1'b0, 2, 6, b);
      cfg_delay = CW'(0);
      cfg_count = CW'(2);
      cfg_tx = 1'b1;
      push_rx(b, 2, 6, 1'b1);
      drain("R7 mid-line config change");

      // R5/R6: early sync pre-empts; edge E2 = E+6 with D=1 leaves 3 words
      t0 = trunc_seen;
      sync_pulse(1'b0, 1, 8, b);
      push_rx(b, 1, 3, 1'b0);
      repeat (4) @(negedge clk);
      sync_pulse(1'b0, 0, 3, b);
      push_rx(b, 0, 3, 1'b1);
      drain("R5 pre-empted rx line");
      check(trunc_seen - t0 == 1, "R6 truncation pulses", trunc_seen - t0, 1);

      // R5: rx line pre-empted by a transmit line
      t0 = trunc_seen;
      sync_pulse(1'b0, 0, 10, b);
      push_rx(b, 0, 2, 1'b0);
      repeat (2) @(negedge clk);
      sync_pulse(1'b1, 1, 3, b);
      push_tx(b, 1, 3);
      drain("R5 rx line pre-empted by tx line");
      check(trunc_seen - t0 == 1, "R6 truncation pulse on direction switch", trunc_seen - t0, 1);

      // R8: zero count ignored when idle
      t0 = trunc_seen;
      sync_pulse(1'b0, 0, 0, b);
      repeat (20) @(negedge clk);
      check(!rx_valid && !bus_oe, "R8 zero count idle", int'({rx_valid, bus_oe}), 0);

      // R8: zero count does not pre-empt a running line
      sync_pulse(1'b0, 0, 6, b);
      push_rx(b, 0, 6, 1'b1);
      sync_pulse(1'b0, 0, 0, b);
      drain("R8 zero count during line");
      check(trunc_seen == t0, "R8 no truncation", trunc_seen - t0, 0);

      // R9: stalled consumer; three words overwrite, two overruns
      t0 = ovr_seen;
      rx_ready = 1'b0;
      sync_pulse(1'b0, 0, 3, b);
      repeat (10) @(negedge clk);
      check(rx_valid && rx_last && rx_data == b + DW'(4), "R9 last word held",
            int'(rx_data), int'(b + DW'(4)));
      check(ovr_seen - t0 == 2, "R9 overrun pulses", ovr_seen - t0, 2);
      rxq.push_back({1'b1, b + DW'(4)});
      rx_ready = 1'b1;
      drain("R9 held word released");
      @(negedge clk);
      check(!rx_valid, "R9 valid drops after accept", int'(rx_valid), 0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule